// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes interrupt vectors of a fixed 32-byte size from a valid/ready input. It writes each accepted vector as one beat into a circular buffer in memory. Software programs where the ring sits and how long it is. The base is a 256-byte-aligned 40-bit byte address, given as its upper 32 bits. The length is given as log2 of the ring size counted in 32-bit words.

The block owns the write pointer. The consumer moves the read pointer through a register-write port. After every advance the new write-pointer word can also be posted on a writeback port, so that software can poll memory instead of a register. That word carries a sticky overflow flag. The flag is set when a vector is written while the ring is full, and it stays set until software clears it.

A ring can instead run in full-drain mode. In that mode it holds the producer off while the ring is full and takes vectors again once the read pointer frees a slot. An interrupt line stays high while the ring is enabled and holds unread vectors.

Top module: `iv_ring_writer`

## Requirements
- R1: After reset the write pointer, read pointer and overflow flag are zero. No memory write or writeback is issued, and the interrupt output is low.
- R2: A vector accepted on a clock edge (vec_valid and vec_ready both high) is presented on the memory port after that edge. It is shown with mem_wr_en high, the vector data, and the address {cfg_base, 8'h00} plus the write pointer as it was before the advance.
- R3: Each accepted vector advances the write pointer by 32 bytes, wrapping modulo the ring size in bytes, which is 4 << cfg_size_log2.
- R4: With cfg_ovf_detect_en high, accepting a vector while the ring is full (write pointer + 32, wrapped, equals the read pointer) sets the overflow flag. The flag is bit 31 of wptr_word; bits [17:0] hold the write pointer and all other bits are zero. The flag stays set until it is cleared.
- R5: A high ovf_clear clears the overflow flag at the next edge. If an overflow happens in the same cycle, the flag is set instead.
- R6: When cfg_wb_en is high at the edge that accepts a vector, wb_valid pulses for one cycle after that edge. wb_word then equals the updated write-pointer word, flag included. With cfg_wb_en low, no writeback is issued.
- R7: While cfg_enable is low, vec_ready is low and the pointers and the overflow flag are forced to zero. Writes to the read pointer are ignored.
- R8: With cfg_full_drain_en high, vec_ready is low while the ring is full. It returns once a read-pointer write frees space, so no vector is overwritten.
- R9: A read-pointer write takes effect at the next edge. The value is masked to the ring size and rounded down to a multiple of 32.
- R10: irq_out is high exactly when the ring is enabled and the read and write pointers differ.
- R11: With overflow detection and full-drain both off, a vector accepted while the ring is full overwrites the oldest one. The flag stays clear and the write pointer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Ring enable |
| cfg_base | input | 32 | Ring base, byte address bits [39:8] |
| cfg_size_log2 | input | 5 | log2 of ring length in 32-bit words |
| cfg_ovf_detect_en | input | 1 | Enable overflow flagging |
| cfg_full_drain_en | input | 1 | Stall producer while full |
| cfg_wb_en | input | 1 | Enable write-pointer writeback |
| ovf_clear | input | 1 | Clear the sticky overflow flag |
| rptr_wr_en | input | 1 | Read-pointer write strobe |
| rptr_wr_data | input | 18 | New read pointer (bytes) |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be taken |
| vec_data | input | 256 | Vector payload |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 40 | Memory byte address |
| mem_wr_data | output | 256 | Memory write data |
| wb_valid | output | 1 | Writeback strobe |
| wb_word | output | 32 | Written-back write-pointer word |
| wptr_word | output | 32 | Current write-pointer word with flag |
| rptr_out | output | 18 | Current read pointer |
| irq_out | output | 1 | Unread vectors present |

## Verification
vec_ready and irq_out are combinational from the current pointers and configuration, so they are checked in the same cycle as the inputs. The memory write, the writeback pulse, and the pointer, read-pointer and flag updates all appear one edge after the stimulus. The bench drives inputs just after a falling edge. A behavioural model advances on each rising edge, and every output is compared with it at the next falling edge, one edge after any stimulus. Directed checks at the end of each scenario compare the write-pointer word with values worked out by hand for wraps, overflow, clear-versus-set and stalled drain.

// File: rtl/iv_ring_pkg.sv
// Shared constants and helpers for the interrupt vector ring writer.
package iv_ring_pkg;
    localparam int unsigned VEC_BYTES = 32;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned FLAG_BIT  = 31;

    // True when byte-pointer bit idx lies inside a ring of 4 << size bytes.
    function automatic logic in_ring(input int unsigned idx, input logic [4:0] size_log2);
        return idx < (int'(size_log2) + 2);
    endfunction

    // Packs the flag and a zero-extended pointer into the write-pointer word.
    function automatic logic [WORD_W-1:0] make_word(input logic flag, input logic [FLAG_BIT-1:0] ptr);
        return {flag, ptr};
    endfunction
endpackage

// File: rtl/iv_ring_ptrs.sv
// Pointer and overflow-flag state for one ring.
// Assumes cfg_size_log2 describes a ring of at least two vectors and PTR_W <= 31.
module iv_ring_ptrs
    import iv_ring_pkg::*;
#(
    parameter int unsigned PTR_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [4:0]       cfg_size_log2,
    input  logic             cfg_ovf_detect_en,
    input  logic             cfg_full_drain_en,
    input  logic             ovf_clear,
    input  logic             rptr_wr_en,
    input  logic [PTR_W-1:0] rptr_wr_data,
    input  logic             vec_valid,
    output logic             vec_ready,
    output logic             accept,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] wptr_d,
    output logic             flag_d,
    output logic [PTR_W-1:0] rptr,
    output logic             flag
);
    localparam logic [PTR_W-1:0] STEP  = PTR_W'(VEC_BYTES);
    localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(VEC_BYTES - 1);

    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] wptr_inc;
    logic [PTR_W-1:0] rptr_d;
    logic             full;

    // Builds the byte mask of the ring from its log2 word count.
    always_comb begin
        for (int i = 0; i < int'(PTR_W); i++) begin
            mask[i] = in_ring(i, cfg_size_log2);
        end
    end

    assign wptr_inc  = (wptr + STEP) & mask;
    assign full      = (wptr_inc == rptr);
    assign vec_ready = cfg_enable && !(cfg_full_drain_en && full);
    assign accept    = vec_valid && vec_ready;

    // Works out next pointer and flag values; disable forces all to zero.
    always_comb begin
        wptr_d = wptr;
        rptr_d = rptr;
        flag_d = flag;
        if (!cfg_enable) begin
            wptr_d = '0;
            rptr_d = '0;
            flag_d = 1'b0;
        end else begin
            if (accept) wptr_d = wptr_inc;
            if (rptr_wr_en) rptr_d = rptr_wr_data & mask & ALIGN;
            if (accept && cfg_ovf_detect_en && full) flag_d = 1'b1;
            else if (ovf_clear) flag_d = 1'b0;
        end
    end

    // Holds the pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            flag <= 1'b0;
        end else begin
            wptr <= wptr_d;
            rptr <= rptr_d;
            flag <= flag_d;
        end
    end
endmodule

// File: rtl/iv_ring_emit.sv
// Registers the memory write beat and the write-pointer writeback for each accepted vector.
// Assumes the pointer inputs are byte offsets already wrapped to the ring.
module iv_ring_emit
    import iv_ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned PTR_W  = 18,
    parameter int unsigned VEC_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cfg_wb_en,
    input  logic [ADDR_W-9:0] cfg_base,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [PTR_W-1:0]  wptr_d,
    input  logic              flag_d,
    input  logic [VEC_W-1:0]  vec_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [VEC_W-1:0]  mem_wr_data,
    output logic              wb_valid,
    output logic [WORD_W-1:0] wb_word
);
    // Strobes follow the accept of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_en <= 1'b0;
            wb_valid  <= 1'b0;
        end else begin
            mem_wr_en <= accept;
            wb_valid  <= accept && cfg_wb_en;
        end
    end

    // Captures address, payload and writeback word on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            wb_word     <= '0;
        end else if (accept) begin
            mem_wr_addr <= {cfg_base, 8'h00} + ADDR_W'(wptr);
            mem_wr_data <= vec_data;
            if (cfg_wb_en) wb_word <= make_word(flag_d, (FLAG_BIT)'(wptr_d));
        end
    end
endmodule

// File: rtl/iv_ring_writer.sv
// Interrupt vector ring writer: accepts 32-byte vectors and writes them into
// a circular buffer in memory, tracking write/read pointers and overflow.
// Assumes ADDR_W > 8, PTR_W <= 31 and a ring of at least two vectors.
module iv_ring_writer
    import iv_ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned PTR_W  = 18,
    parameter int unsigned VEC_W  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [ADDR_W-9:0] cfg_base,
    input  logic [4:0]        cfg_size_log2,
    input  logic              cfg_ovf_detect_en,
    input  logic              cfg_full_drain_en,
    input  logic              cfg_wb_en,
    input  logic              ovf_clear,
    input  logic              rptr_wr_en,
    input  logic [PTR_W-1:0]  rptr_wr_data,
    input  logic              vec_valid,
    output logic              vec_ready,
    input  logic [VEC_W-1:0]  vec_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [VEC_W-1:0]  mem_wr_data,
    output logic              wb_valid,
    output logic [WORD_W-1:0] wb_word,
    output logic [WORD_W-1:0] wptr_word,
    output logic [PTR_W-1:0]  rptr_out,
    output logic              irq_out
);
    logic             accept;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] wptr_d;
    logic             flag;
    logic             flag_d;

    iv_ring_ptrs #(.PTR_W(PTR_W)) u_ptrs (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_enable        (cfg_enable),
        .cfg_size_log2     (cfg_size_log2),
        .cfg_ovf_detect_en (cfg_ovf_detect_en),
        .cfg_full_drain_en (cfg_full_drain_en),
        .ovf_clear         (ovf_clear),
        .rptr_wr_en        (rptr_wr_en),
        .rptr_wr_data      (rptr_wr_data),
        .vec_valid         (vec_valid),
        .vec_ready         (vec_ready),
        .accept            (accept),
        .wptr              (wptr),
        .wptr_d            (wptr_d),
        .flag_d            (flag_d),
        .rptr              (rptr_out),
        .flag              (flag)
    );

    iv_ring_emit #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .VEC_W(VEC_W)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .cfg_wb_en   (cfg_wb_en),
        .cfg_base    (cfg_base),
        .wptr        (wptr),
        .wptr_d      (wptr_d),
        .flag_d      (flag_d),
        .vec_data    (vec_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .wb_valid    (wb_valid),
        .wb_word     (wb_word)
    );

    assign wptr_word = make_word(flag, (FLAG_BIT)'(wptr));
    assign irq_out   = cfg_enable && (wptr != rptr_out);
endmodule

// File: rtl/iv_ring_writer_chk.sv
// Property checker for the ring writer, attached by bind.
module iv_ring_writer_chk
    import iv_ring_pkg::*;
#(
    parameter int unsigned PTR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic [4:0]        cfg_size_log2,
    input logic              cfg_full_drain_en,
    input logic              ovf_clear,
    input logic              vec_valid,
    input logic              vec_ready,
    input logic              mem_wr_en,
    input logic              wb_valid,
    input logic [WORD_W-1:0] wb_word,
    input logic [WORD_W-1:0] wptr_word,
    input logic [PTR_W-1:0]  rptr_out
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(VEC_BYTES);

    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] wp;
    logic             full;

    // Independent ring mask and fullness seen from the ports.
    always_comb begin
        for (int i = 0; i < int'(PTR_W); i++) begin
            mask[i] = in_ring(i, cfg_size_log2);
        end
    end
    assign wp   = wptr_word[PTR_W-1:0];
    assign full = (((wp + STEP) & mask) == rptr_out);

    assert_accept_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready) |=> mem_wr_en);
    assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && vec_ready) |=> !mem_wr_en);
    assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_ready) |=> (wp == (($past(wp) + STEP) & $past(mask))));
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_word[FLAG_BIT] && !ovf_clear && cfg_enable) |=> wptr_word[FLAG_BIT]);
    assert_wb_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_word == wptr_word));
    assert_disable_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (wptr_word == '0 && rptr_out == '0));
    assert_drain_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && cfg_full_drain_en && full) |-> !vec_ready);
endmodule

bind iv_ring_writer iv_ring_writer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cfg_enable        (cfg_enable),
    .cfg_size_log2     (cfg_size_log2),
    .cfg_full_drain_en (cfg_full_drain_en),
    .ovf_clear         (ovf_clear),
    .vec_valid         (vec_valid),
    .vec_ready         (vec_ready),
    .mem_wr_en         (mem_wr_en),
    .wb_valid          (wb_valid),
    .wb_word           (wb_word),
    .wptr_word         (wptr_word),
    .rptr_out          (rptr_out)
);

// File: tb/iv_ring_writer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural ring model advanced on each rising edge, compared on each falling edge.
module iv_ring_writer_bench;
    localparam int PTR_W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_enable = 1'b0;
    logic [31:0]  cfg_base = 32'h0;
    logic [4:0]   cfg_size_log2 = 5'd5;
    logic         cfg_ovf_detect_en = 1'b0;
    logic         cfg_full_drain_en = 1'b0;
    logic         cfg_wb_en = 1'b0;
    logic         ovf_clear = 1'b0;
    logic         rptr_wr_en = 1'b0;
    logic [17:0]  rptr_wr_data = '0;
    logic         vec_valid = 1'b0;
    logic         vec_ready;
    logic [255:0] vec_data = '0;
    logic         mem_wr_en;
    logic [39:0]  mem_wr_addr;
    logic [255:0] mem_wr_data;
    logic         wb_valid;
    logic [31:0]  wb_word;
    logic [31:0]  wptr_word;
    logic [17:0]  rptr_out;
    logic         irq_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int seq = 1;

    // reference model state
    longint m_w = 0, m_r = 0, m_flag = 0;
    bit m_mem_en = 0, m_wb_valid = 0;
    longint m_addr = 0, m_wb_word = 0;
    logic [255:0] m_data = '0;

    always #2.5 clk = ~clk;

    iv_ring_writer u_iv_ring_writer (.*);

    function automatic longint ring_bytes();
        if (int'(cfg_size_log2) + 2 >= PTR_W) return longint'(1) << PTR_W;
        return longint'(4) << cfg_size_log2;
    endfunction

    function automatic bit model_full();
        return ((m_w + 32) % ring_bytes()) == m_r;
    endfunction

    function automatic bit model_ready();
        return cfg_enable && !(cfg_full_drain_en && model_full());
    endfunction

    always @(posedge clk) begin
        bit acc, fl;
        m_mem_en = 0;
        m_wb_valid = 0;
        if (!rst_n || !cfg_enable) begin
            m_w = 0; m_r = 0; m_flag = 0;
        end else begin
            acc = vec_valid && model_ready();
            fl = model_full();
            if (acc && cfg_ovf_detect_en && fl) m_flag = 1;
            else if (ovf_clear) m_flag = 0;
            if (acc) begin
                m_mem_en = 1;
                m_addr = longint'(cfg_base) * 256 + m_w;
                m_data = vec_data;
                m_w = (m_w + 32) % ring_bytes();
            end
            if (rptr_wr_en) m_r = (longint'(rptr_wr_data) % ring_bytes()) / 32 * 32;
            if (acc && cfg_wb_en) begin
                m_wb_valid = 1;
                m_wb_word = (m_flag << 31) | m_w;
            end
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_data(input string tag, input logic [255:0] act, input logic [255:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        if (!rst_n) return;
        check("R8 vec_ready", longint'(vec_ready), longint'(model_ready()));
        check("R10 irq_out", longint'(irq_out), longint'(cfg_enable && (m_w != m_r)));
        check("R3 write pointer", longint'(wptr_word[17:0]), m_w);
        check("R4 overflow flag", longint'(wptr_word[31]), m_flag);
        check("R9 read pointer", longint'(rptr_out), m_r);
        check("R2 mem_wr_en", longint'(mem_wr_en), longint'(m_mem_en));
        if (m_mem_en) begin
            check("R2 mem_wr_addr", longint'(mem_wr_addr), m_addr);
            check_data("R2 mem_wr_data", mem_wr_data, m_data);
        end
        check("R6 wb_valid", longint'(wb_valid), longint'(m_wb_valid));
        if (m_wb_valid) check("R6 wb_word", longint'(wb_word), m_wb_word);
    endtask

    task automatic tick();
        @(negedge clk);
        #0.5;
        compare_all();
    endtask

    task automatic push(input int n);
        vec_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            vec_data = {8{seq[31:0]}};
            seq++;
            tick();
        end
        vec_valid = 1'b0;
    endtask

    task automatic write_rptr(input logic [17:0] v);
        rptr_wr_en = 1'b1;
        rptr_wr_data = v;
        tick();
        rptr_wr_en = 1'b0;
    endtask

    initial begin
        repeat (4) tick();
        check("R1 wptr_word after reset", longint'(wptr_word), 0);
        check("R1 irq after reset", longint'(irq_out), 0);
        check("R1 mem_wr_en after reset", longint'(mem_wr_en), 0);
        check("R1 wb_valid after reset", longint'(wb_valid), 0);
        rst_n = 1'b1;
        cfg_enable = 1'b1; cfg_base = 32'h12345; cfg_size_log2 = 5'd5;
        cfg_ovf_detect_en = 1'b1; cfg_wb_en = 1'b1;
        tick();
        check("R1 rptr after reset", longint'(rptr_out), 0);
        // fill: three vectors make a 128-byte ring full
        push(3);
        check("R3 wptr after three", longint'(wptr_word), 32'h60);
        check("R10 irq pending", longint'(irq_out), 1);
        // overflow and wrap
        push(1);
        check("R4 overflow set and wrapped", longint'(wptr_word), 32'h8000_0000);
        repeat (3) tick();
        check("R4 overflow sticky", longint'(wptr_word[31]), 1);
        // recovery: rptr to wptr+32, then clear
        write_rptr(18'h20);
        ovf_clear = 1'b1; tick(); ovf_clear = 1'b0;
        check("R5 flag cleared", longint'(wptr_word), 0);
        check("R9 recovery rptr", longint'(rptr_out), 32'h20);
        // overflow and clear in the same cycle: set wins
        ovf_clear = 1'b1; push(1); ovf_clear = 1'b0;
        check("R5 set beats clear", longint'(wptr_word), 32'h8000_0020);
        ovf_clear = 1'b1; tick(); ovf_clear = 1'b0;
        check("R5 second clear", longint'(wptr_word), 32'h20);
        // full-drain mode
        cfg_ovf_detect_en = 1'b0; cfg_full_drain_en = 1'b1;
        vec_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin vec_data = {8{seq[31:0]}}; seq++; tick(); end
        check("R8 stalled at full", longint'(wptr_word), 0);
        check("R8 ready low when full", longint'(vec_ready), 0);
        rptr_wr_en = 1'b1; rptr_wr_data = 18'h40; tick(); rptr_wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin vec_data = {8{seq[31:0]}}; seq++; tick(); end
        vec_valid = 1'b0;
        check("R8 resumed one slot", longint'(wptr_word), 32'h20);
        // silent overwrite
        cfg_full_drain_en = 1'b0;
        push(2);
        check("R11 overwrite without flag", longint'(wptr_word), 32'h60);
        // writeback off
        cfg_wb_en = 1'b0;
        push(1);
        check("R6 no writeback when off", longint'(wb_valid), 0);
        cfg_wb_en = 1'b1;
        // disable
        cfg_enable = 1'b0;
        tick();
        write_rptr(18'h40);
        check("R7 wptr zero when disabled", longint'(wptr_word), 0);
        check("R7 rptr write ignored", longint'(rptr_out), 0);
        check("R7 ready low when disabled", longint'(vec_ready), 0);
        // smaller ring, overflow at wrap
        cfg_enable = 1'b1; cfg_size_log2 = 5'd4; cfg_ovf_detect_en = 1'b1;
        tick();
        push(3);
        check("R3 R4 small ring", longint'(wptr_word), 32'h8000_0020);
        write_rptr(18'h1FFFF);
        check("R9 masked rptr", longint'(rptr_out), 32'h20);
        check("R10 irq low when equal", longint'(irq_out), 0);
        repeat (2) tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule